// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block sits between a host register bus and the frame logic of an AC'97 link. It carries codec register reads and writes over the command slot (slot 1) and the data slot (slot 2). The host stages an optional write value in the slot-2 transmit register. It then writes the command word to the slot-1 transmit register. A command word holds the register index and a read flag. That slot-1 write arms both slots. At each following frame tick the engine presents the armed words, with their tag bits, to the frame serialiser, and it keeps each slot busy until the frame that carried it has ended.

In the other direction, the frame logic hands over the returned slot-1 and slot-2 words with their incoming slot-0 tag bits. The engine captures each tagged slot whose receive path is enabled and raises a per-slot valid flag. Reading the matching receive register clears that flag. A codec answers a read roughly two frames later, and the host compares the returned index with the one it asked for. A 2-bit select field in the control register is driven out to choose one of four codecs. Clearing the interface enable drops every busy flag, valid flag and tag.

Frame-side words move on the fixed frame cadence, so there is no back-pressure. `frame_tick` and `rx_strobe` are single-cycle strobes that the engine always accepts. The register side uses plain one-cycle `reg_wr` and `reg_rd` strobes. The read data is combinational from `reg_addr`.

Top module: `ac97_cmd_engine`

## Requirements
- R1: After reset, the flag register (address 4) and the control register (address 5) read 0. Both `tx_tag` bits are 0, and `tx_slot1`, `tx_slot2` and `codec_sel` are 0.
- R2: A write to address 0 (slot-1 transmit) sets busy flag bit 0. If the slot-1 transmit enable is set, the next `frame_tick` raises `tx_tag[0]` and drives the written word on `tx_slot1`. In that word, bit 19 is the read flag, bits 18:12 are the register index and bits 11:0 are zero.
- R3: A write to address 1 (slot-2 transmit, data in bits 19:4) sets busy flag bit 1 but launches nothing, so a `frame_tick` leaves `tx_tag[1]` at 0. The next slot-1 write arms it, and it goes out on `tx_slot2` with `tx_tag[1]` in the same frame as slot 1.
- R4: While a slot's transmit enable is clear (control bit 1 for slot 1, bit 2 for slot 2), a `frame_tick` does not raise that slot's tag, and its busy flag stays set. It launches at the first tick after the enable is set.
- R5: Tags change only on a `frame_tick` or a flush. The tick that ends the frame which carried a slot drops its tag and clears its busy flag, unless the slot has been armed again.
- R6: A `rx_strobe` with `rx_tag[n]` set captures that slot's word and sets its valid flag, but only if the slot's receive enable is set (control bit 3 for slot 1, bit 4 for slot 2). Valid bits sit at flag bits 2 and 3. The captured words read back at addresses 2 and 3.
- R7: A `reg_rd` of address 2 or 3 clears the matching valid flag. If a capture for that slot falls in the same cycle, the capture wins: the flag stays set and the new word is held.
- R8: A new capture overwrites a captured word that has not been read.
- R9: While the interface enable (control bit 0) is 0, the engine clears every busy flag, valid flag and tag, one clock after the control register takes the 0. Transmit writes made while it is 0 are dropped.
- R10: Control bits 6:5 drive `codec_sel`, and the control register reads back as written in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive valid) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data, combinational from reg_addr |
| frame_tick | input | 1 | Frame boundary strobe |
| tx_slot1 | output | 20 | Outgoing command slot word |
| tx_slot2 | output | 20 | Outgoing data slot word |
| tx_tag | output | 2 | Outgoing slot-0 tags, bit 0 slot 1, bit 1 slot 2 |
| rx_strobe | input | 1 | Returned slots present |
| rx_tag | input | 2 | Incoming slot-0 tags, bit 0 slot 1, bit 1 slot 2 |
| rx_slot1 | input | 20 | Returned command slot word |
| rx_slot2 | input | 20 | Returned data slot word |
| codec_sel | output | 2 | Selected codec |

## Verification
A receive-register read and a fresh capture for the same slot can fall in the same clock. The bench raises `reg_rd` on the slot-2 receive address in the cycle where `rx_strobe` carries a tagged slot 2. It expects the valid flag to stay set and the new word to read back, and a later read to clear the flag. A slot-1 write and a frame tick can also meet: a slot that is re-armed in the tick that ends its frame must stay busy. That case is checked through the busy flags and through the tag that comes up at the following tick.

// File: rtl/ac97_eng_pkg.sv
package ac97_eng_pkg;
  localparam int SLOT_W  = 20;
  localparam int CSEL_W  = 2;
  localparam int NSLOT   = 2;

  typedef enum logic [2:0] {
    A_S1TX = 3'd0,
    A_S2TX = 3'd1,
    A_S1RX = 3'd2,
    A_S2RX = 3'd3,
    A_FLAG = 3'd4,
    A_CTRL = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [CSEL_W-1:0] csel;
    logic              rx2_en;
    logic              rx1_en;
    logic              tx2_en;
    logic              tx1_en;
    logic              glb_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ac97_tx_slot.sv
module ac97_tx_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         enable,
  input  logic         store,
  input  logic         arm,
  input  logic [W-1:0] din,
  input  logic         frame_tick,
  output logic [W-1:0] word,
  output logic         tag,
  output logic         busy
);
  logic [W-1:0] hold;
  logic         staged, loaded;
  logic         launch;

  assign launch = frame_tick && loaded && enable;
  assign busy   = staged | loaded | tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= '0;
      word   <= '0;
      staged <= 1'b0;
      loaded <= 1'b0;
      tag    <= 1'b0;
    end else if (flush) begin
      staged <= 1'b0;
      loaded <= 1'b0;
      tag    <= 1'b0;
    end else begin
      if (store) begin
        hold   <= din;
        staged <= 1'b1;
      end
      if (frame_tick) begin
        tag <= launch;
        if (launch) word <= hold;
      end
      if (arm && (staged || store)) begin
        loaded <= 1'b1;
        staged <= 1'b0;
      end else if (launch) begin
        loaded <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ac97_rx_slot.sv
module ac97_rx_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         capture,
  input  logic [W-1:0] din,
  input  logic         clr,
  output logic [W-1:0] word,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (capture) begin
      word  <= din;
      valid <= 1'b1;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine
  import ac97_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic [SLOT_W-1:0] reg_rdata,
  input  logic              frame_tick,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic [SLOT_W-1:0] tx_slot2,
  output logic [NSLOT-1:0]  tx_tag,
  input  logic              rx_strobe,
  input  logic [NSLOT-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot2,
  output logic [CSEL_W-1:0] codec_sel
);
  ctrl_t             ctrl_q;
  logic              glb_en;
  logic [NSLOT-1:0]  tx_en, rx_en;
  logic [NSLOT-1:0]  tx_store, tx_busy;
  logic [NSLOT-1:0]  rx_cap, rx_clr, rx_valid;
  logic [SLOT_W-1:0] tx_word [NSLOT];
  logic [SLOT_W-1:0] rx_in   [NSLOT];
  logic [SLOT_W-1:0] rx_word [NSLOT];
  logic              arm_cmd;

  assign glb_en    = ctrl_q.glb_en;
  assign tx_en     = {ctrl_q.tx2_en, ctrl_q.tx1_en};
  assign rx_en     = {ctrl_q.rx2_en, ctrl_q.rx1_en};
  assign codec_sel = ctrl_q.csel;
  assign arm_cmd   = reg_wr && (reg_addr == A_S1TX);
  assign rx_in[0]  = rx_slot1;
  assign rx_in[1]  = rx_slot2;
  assign tx_slot1  = tx_word[0];
  assign tx_slot2  = tx_word[1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL)
      ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign tx_store[g] = reg_wr && (reg_addr == 3'(A_S1TX + g));
    assign rx_cap[g]   = rx_strobe && rx_tag[g] && rx_en[g];
    assign rx_clr[g]   = reg_rd && (reg_addr == 3'(A_S1RX + g));

    ac97_tx_slot #(.W(SLOT_W)) tx_i (
      .clk(clk), .rst_n(rst_n), .flush(!glb_en), .enable(tx_en[g]),
      .store(tx_store[g]), .arm(arm_cmd), .din(reg_wdata),
      .frame_tick(frame_tick), .word(tx_word[g]), .tag(tx_tag[g]),
      .busy(tx_busy[g])
    );

    ac97_rx_slot #(.W(SLOT_W)) rx_i (
      .clk(clk), .rst_n(rst_n), .flush(!glb_en), .capture(rx_cap[g]),
      .din(rx_in[g]), .clr(rx_clr[g]), .word(rx_word[g]),
      .valid(rx_valid[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_S1RX: reg_rdata = rx_word[0];
      A_S2RX: reg_rdata = rx_word[1];
      A_FLAG: reg_rdata[3:0] = {rx_valid, tx_busy};
      A_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ac97_cmd_engine_chk.sv
module ac97_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       glb_en,
  input logic [1:0] tx_tag,
  input logic [1:0] busy,
  input logic [1:0] valid,
  input logic       rx_strobe,
  input logic [1:0] rd_clr,
  input logic [1:0] cap
);
  // R5
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && glb_en) |=> $stable(tx_tag));

  // R2
  tag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag & ~busy) == 2'b00);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (busy == 2'b00 && valid == 2'b00 && tx_tag == 2'b00));

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid & ~$past(valid)) != 2'b00) |-> $past(rx_strobe));

  // R7
  rd_clear1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr[0] && !cap[0]) |=> !valid[0]);

  // R7
  rd_clear2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr[1] && !cap[1]) |=> !valid[1]);
endmodule

bind ac97_cmd_engine ac97_cmd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .glb_en(glb_en),
  .tx_tag(tx_tag), .busy(tx_busy), .valid(rx_valid),
  .rx_strobe(rx_strobe), .rd_clr(rx_clr), .cap(rx_cap)
);

// File: tb/ac97_cmd_engine_tb_top.sv
module ac97_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic        frame_tick = 1'b0;
  logic [19:0] tx_slot1, tx_slot2;
  logic [1:0]  tx_tag;
  logic        rx_strobe = 1'b0;
  logic [1:0]  rx_tag = 2'b00;
  logic [19:0] rx_slot1 = '0, rx_slot2 = '0;
  logic [1:0]  codec_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ac97_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_tick(frame_tick), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2),
    .tx_tag(tx_tag), .rx_strobe(rx_strobe), .rx_tag(rx_tag),
    .rx_slot1(rx_slot1), .rx_slot2(rx_slot2), .codec_sel(codec_sel)
  );

  // {read flag, index[6:0], write data[15:0]}
  localparam logic [23:0] CMD_TAB [6] = '{
    {1'b0, 7'h02, 16'h8000},
    {1'b0, 7'h7E, 16'hFFFF},
    {1'b1, 7'h26, 16'h0000},
    {1'b0, 7'h00, 16'h0001},
    {1'b1, 7'h7C, 16'h0000},
    {1'b0, 7'h18, 16'h0808}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [19:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_clear(input logic [2:0] a);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic rx(input logic [1:0] t, input logic [19:0] w1, input logic [19:0] w2);
    rx_strobe = 1'b1; rx_tag = t; rx_slot1 = w1; rx_slot2 = w2;
    @(negedge clk);
    rx_strobe = 1'b0; rx_tag = 2'b00;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    logic [19:0] w1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd4, v); chk("R1 flags", v, 0);
    peek(3'd5, v); chk("R1 ctrl", v, 0);
    chk("R1 tags", tx_tag, 0);
    chk("R1 slot words", {tx_slot1, tx_slot2}, 0);
    chk("R1 codec_sel", codec_sel, 0);

    // R10 control readback and codec select
    wr(3'd5, 20'h0005F);
    chk("R10 codec_sel", codec_sel, 2);
    peek(3'd5, v); chk("R10 ctrl readback", v, 20'h5F);

    // R2 R3 R5 command table
    for (int i = 0; i < 6; i++) begin
      logic rdf; logic [6:0] idx; logic [15:0] dat;
      {rdf, idx, dat} = CMD_TAB[i];
      w1 = {rdf, idx, 12'h000};
      if (!rdf) begin
        wr(3'd1, {dat, 4'h0});
        peek(3'd4, v); chk("R3 slot2 staged busy", v[1:0], 2'b10);
        tick();
        chk("R3 slot2 not launched alone", tx_tag, 2'b00);
      end
      wr(3'd0, w1);
      peek(3'd4, v); chk("R2 busy after slot1 write", v[1:0], {!rdf, 1'b1});
      tick();
      chk("R2 tags in frame", tx_tag, {!rdf, 1'b1});
      chk("R2 slot1 word", tx_slot1, w1);
      if (!rdf) chk("R3 slot2 word", tx_slot2, {dat, 4'h0});
      tick();
      chk("R5 tags drop", tx_tag, 2'b00);
      peek(3'd4, v); chk("R5 busy clear", v[1:0], 2'b00);
    end

    // R5 re-armed in the tick that ends its frame
    wr(3'd0, 20'h11000);
    tick();
    chk("R5 first launch", tx_tag, 2'b01);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 20'h22000; frame_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_tick = 1'b0;
    chk("R5 tag drops at end tick", tx_tag, 2'b00);
    peek(3'd4, v); chk("R5 re-armed stays busy", v[0], 1'b1);
    tick();
    chk("R5 relaunch tag", tx_tag, 2'b01);
    chk("R5 relaunch word", tx_slot1, 20'h22000);
    tick();

    // R4 slot-1 transmit enable clear
    wr(3'd5, 20'h0001D);
    wr(3'd0, 20'h05000);
    tick();
    chk("R4 no tag while disabled", tx_tag, 2'b00);
    peek(3'd4, v); chk("R4 busy held", v[0], 1'b1);
    wr(3'd5, 20'h0001F);
    tick();
    chk("R4 launch after enable", tx_tag, 2'b01);
    chk("R4 word", tx_slot1, 20'h05000);
    tick();

    // R6 capture
    rx(2'b01, 20'hA1234, 20'hB5678);
    peek(3'd4, v); chk("R6 valid slot1 only", v[3:2], 2'b01);
    peek(3'd2, v); chk("R6 slot1 data", v, 20'hA1234);
    rx(2'b10, 20'h0, 20'hB5678);
    peek(3'd4, v); chk("R6 valid both", v[3:2], 2'b11);
    peek(3'd3, v); chk("R6 slot2 data", v, 20'hB5678);

    // R8 overwrite unread
    rx(2'b01, 20'hC0FFE, 20'h0);
    peek(3'd2, v); chk("R8 overwrite", v, 20'hC0FFE);

    // R7 read clears, capture wins on collision
    rd_clear(3'd2);
    peek(3'd4, v); chk("R7 read clears valid1", v[3:2], 2'b10);
    reg_addr = 3'd3; reg_rd = 1'b1;
    rx_strobe = 1'b1; rx_tag = 2'b10; rx_slot2 = 20'hD00D1;
    @(negedge clk);
    reg_rd = 1'b0; rx_strobe = 1'b0; rx_tag = 2'b00;
    peek(3'd4, v); chk("R7 capture wins valid", v[3], 1'b1);
    peek(3'd3, v); chk("R7 capture wins data", v, 20'hD00D1);
    rd_clear(3'd3);
    peek(3'd4, v); chk("R7 later read clears", v[3], 1'b0);

    // R6 receive enable clear
    wr(3'd5, 20'h00017);
    rx(2'b01, 20'h12345, 20'h0);
    peek(3'd4, v); chk("R6 disabled rx ignored", v[2], 1'b0);
    peek(3'd2, v); chk("R6 disabled rx keeps word", v, 20'hC0FFE);

    // R9 flush
    wr(3'd5, 20'h0001F);
    wr(3'd1, 20'h33330);
    rx(2'b10, 20'h0, 20'h77777);
    wr(3'd0, 20'h02000);
    tick();
    chk("R9 precondition tags", tx_tag, 2'b11);
    wr(3'd1, 20'h44440);
    wr(3'd5, 20'h0001E);
    @(negedge clk);
    peek(3'd4, v); chk("R9 flags flushed", v[3:0], 4'h0);
    chk("R9 tags flushed", tx_tag, 2'b00);
    wr(3'd0, 20'h03000);
    peek(3'd4, v); chk("R9 write dropped", v[1:0], 2'b00);
    wr(3'd5, 20'h0001F);
    tick();
    chk("R9 nothing launches after re-enable", tx_tag, 2'b00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule